// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address sequence for a four-beat burst access to a synchronous burst memory. A burst starts when either of two start strobes is high at a rising clock edge. One strobe serves a processor-side master and the other a cache-controller-side master. The block then loads the full start address and resets its beat position to zero. On later edges, an asserted advance input moves the burst to its next beat. Only the two least significant address bits change. The upper bits keep the value captured at the start.

An order strap selects how the low two bits step. With linear order they count upward from the start value, modulo four. With interleaved order they are the start bits XORed with the beat number. The strap is meant to be tied on the board, with a pull-up so that an open pin gives interleaved order. The block samples it once, at the first clock edge after reset is released, and ignores it after that. Both the current address and the current beat number are available continuously as outputs. The current address drives the memory array directly.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted (rst_n low), cur_addr and beat_pos are both zero.
- R2: If strobe_proc or strobe_cache is high at a rising edge, with either one or both high, cur_addr equals the start_addr sampled at that edge and beat_pos is 0 after that edge.
- R3: If advance is high and neither strobe is high at an edge, beat_pos becomes the previous beat_pos plus one, modulo 4.
- R4: In linear order (strap value 0), cur_addr[1:0] equals (start bits + beat_pos) modulo 4.
- R5: In interleaved order (strap value 1), cur_addr[1:0] equals start bits XOR beat_pos.
- R6: cur_addr above bit 1 keeps the loaded value while bursting, with no carry out of the low two bits.
- R7: If neither strobe nor advance is high at an edge, cur_addr and beat_pos keep their values, and start_addr has no effect.
- R8: If a strobe and advance are both high at an edge, the strobe takes effect: the new address is loaded and beat_pos becomes 0.
- R9: order_sel is sampled at the first rising edge after reset release. Later changes have no effect on the order until the next reset.
- R10: Advancing from beat 3 wraps to beat 0, which gives the burst's start address again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strobe_proc | input | 1 | Processor-side burst start strobe |
| strobe_cache | input | 1 | Cache-controller-side burst start strobe |
| advance | input | 1 | Step to the next beat of the burst |
| order_sel | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| start_addr | input | ADDR_W | Burst start address, sampled with a strobe |
| cur_addr | output | ADDR_W | Current beat address |
| beat_pos | output | 2 | Current beat number within the burst |

## Verification
The hardest case to reach from the ports is the order strap. It can be set only in the single edge after reset release, so a change to it must be seen to have no effect. The bench therefore resets twice. After the second reset it holds the strap low through the first edge and then flips it high, and then checks that a whole burst still follows linear order. A start value of 3 is used in linear order so that a low-bit wrap that carried into the upper bits would show in cur_addr.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_mode_strap.sv
module burst_mode_strap
  import burst_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         order_pin,
  output burst_order_e order_o
);
  logic         taken_q, taken_d;
  burst_order_e mode_q, mode_d;

  always_comb begin
    taken_d = taken_q;
    mode_d  = mode_q;
    if (!taken_q) begin
      taken_d = 1'b1;
      mode_d  = burst_order_e'(order_pin);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      mode_q  <= ORD_INTERLEAVE;
    end else begin
      taken_q <= taken_d;
      mode_q  <= mode_d;
    end
  end

  // the strap is live only in the capture edge itself
  assign order_o = taken_q ? mode_q : burst_order_e'(order_pin);

  a_r9_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q |=> $stable(mode_q));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign cnt_en = load | step;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign beat_o = cnt_q;

  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cnt_q == BEAT_W'($past(cnt_q) + 1'b1)));
  a_r8_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == '0));
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  logic [ADDR_W-1:0] base_q, base_d;

  always_comb begin
    base_d = base_q;
    if (load) base_d = addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= base_d;
  end

  assign base_o = base_q;

  a_r2_base_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (base_q == $past(addr_i)));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_proc,
  input  logic              strobe_cache,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        beat_pos
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic              start_any;
  logic              step_beat;
  burst_order_e      order;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low_lin, low_ilv, low_sel;

  assign start_any = strobe_proc | strobe_cache;
  assign step_beat = advance & ~start_any;

  burst_mode_strap u_strap (
    .clk       (clk),
    .rst_n     (rst_n),
    .order_pin (order_sel),
    .order_o   (order)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start_any),
    .addr_i (start_addr),
    .base_o (base)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start_any),
    .step   (step_beat),
    .beat_o (beat)
  );

  // The low bits are formed from the start bits and the beat number without
  // an address register, so a strobe costs no extra latency.
  assign low_lin = base[BEAT_W-1:0] + beat;
  assign low_ilv = base[BEAT_W-1:0] ^ beat;

  always_comb begin
    unique case (order)
      ORD_LINEAR:     low_sel = low_lin;
      ORD_INTERLEAVE: low_sel = low_ilv;
      default:        low_sel = low_ilv;
    endcase
  end

  assign cur_addr = {base[ADDR_W-1:BEAT_W], low_sel};
  assign beat_pos = beat;

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start_any |=> (cur_addr == $past(start_addr) && beat_pos == 2'd0));
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_any && !advance) |=> ($stable(cur_addr) && $stable(beat_pos)));
  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !start_any |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |-> (cur_addr == '0 && beat_pos == 2'd0));

  if (HI_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed the beat width");
  end
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int unsigned ADDR_W = 20;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned NVEC = 11;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              strobe_proc, strobe_cache, advance, order_sel;
  logic [ADDR_W-1:0] start_addr;
  logic [ADDR_W-1:0] cur_addr;
  logic [1:0]        beat_pos;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) i_burst_addr_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_proc  (strobe_proc),
    .strobe_cache (strobe_cache),
    .advance      (advance),
    .order_sel    (order_sel),
    .start_addr   (start_addr),
    .cur_addr     (cur_addr),
    .beat_pos     (beat_pos)
  );

  // {strobe_proc, strobe_cache, advance, start_addr, exp_addr, exp_beat}
  // interleaved order (strap high)
  localparam logic [44:0] VEC [NVEC] = '{
    {3'b100, 20'hABCD6, 20'hABCD6, 2'd0}, // R2 processor strobe
    {3'b001, 20'h00000, 20'hABCD7, 2'd1}, // R5 R3
    {3'b001, 20'h00000, 20'hABCD4, 2'd2}, // R5
    {3'b000, 20'h55555, 20'hABCD4, 2'd2}, // R7 hold
    {3'b001, 20'h00000, 20'hABCD5, 2'd3}, // R5
    {3'b001, 20'h00000, 20'hABCD6, 2'd0}, // R10 wrap
    {3'b011, 20'h12341, 20'h12341, 2'd0}, // R8 cache strobe beats advance
    {3'b001, 20'h00000, 20'h12340, 2'd1}, // R5
    {3'b110, 20'hFFFFF, 20'hFFFFF, 2'd0}, // R2 both strobes
    {3'b001, 20'h00000, 20'hFFFFE, 2'd1}, // R6 upper kept
    {3'b000, 20'h00000, 20'hFFFFE, 2'd1}  // R7 address ignored
  };

  task automatic check(input string req, input logic [ADDR_W-1:0] ea,
                       input logic [1:0] eb);
    checks++;
    if (cur_addr !== ea || beat_pos !== eb) begin
      errors++;
      $display("FAIL %s addr=%h beat=%0d expected addr=%h beat=%0d",
               req, cur_addr, beat_pos, ea, eb);
    end
  endtask

  task automatic cycle(input logic sp, input logic sc, input logic adv,
                       input logic [ADDR_W-1:0] a);
    @(negedge clk);
    strobe_proc = sp; strobe_cache = sc; advance = adv; start_addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; order_sel = strap;
    strobe_proc = 0; strobe_cache = 0; advance = 0; start_addr = '0;
    #(CLK_PERIOD*2);
    check("R1", '0, 2'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD*2000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; order_sel = 1'b1;
    strobe_proc = 0; strobe_cache = 0; advance = 0; start_addr = '0;
    #1;
    check("R1", '0, 2'd0);
    do_reset(1'b1);

    for (int i = 0; i < NVEC; i++) begin
      cycle(VEC[i][44], VEC[i][43], VEC[i][42], VEC[i][41:22]);
      check($sformatf("vec%0d", i), VEC[i][21:2], VEC[i][1:0]);
    end

    // R1 after activity; R9 capture linear then flip strap
    do_reset(1'b0);
    cycle(0, 0, 0, '0);  // capture edge with strap low
    order_sel = 1'b1;    // R9 later change must be ignored
    cycle(1, 0, 0, 20'h00003);
    check("R2", 20'h00003, 2'd0);
    cycle(0, 0, 1, '0);
    check("R4 R6 R9", 20'h00000, 2'd1);
    cycle(0, 0, 1, '0);
    check("R4", 20'h00001, 2'd2);
    cycle(0, 0, 1, '0);
    check("R4", 20'h00002, 2'd3);
    cycle(0, 0, 1, '0);
    check("R10", 20'h00003, 2'd0);
    cycle(0, 1, 0, 20'h7A5F1);
    cycle(0, 0, 1, '0);
    check("R4 R3", 20'h7A5F2, 2'd1);
    cycle(0, 0, 0, 20'h11111);
    check("R7", 20'h7A5F2, 2'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule